// File: doc/BRIEF.md
# Robust Asynchronous Serial Byte Receiver

This block takes one asynchronous serial line and turns it into bytes for a parallel reader. Each frame is one low start bit, eight data bits with the least significant bit first, and one high stop bit. The bit period comes from two parameters: the system clock frequency and the baud rate. Several instances can therefore sit side by side at different rates, and moving to a new clock needs only a new parameter value.

The receiver realigns its timing on the falling edge of every start bit, so small rate errors do not build up from one character to the next. A start pulse that is gone by half a bit period counts as a glitch. A frame whose stop bit samples low is thrown away. There is no queue. One holding register keeps the newest good byte, and a valid flag marks it as unread. A newer good byte replaces an unread one. A read strobe clears the flag.

Top module: `serial_byte_rx`

## Requirements
- R1: After reset `valid_o` is 0 and `data_o` is 0x00.
- R2: A frame of one low start bit, eight data bits least significant bit first, and one high stop bit, each lasting CPB clock cycles, loads the eight data bits into `data_o` (first data bit in bit 0) and sets `valid_o`.
- R3: A frame whose stop bit samples low changes neither `data_o` nor `valid_o`, whatever their earlier values.
- R4: A good frame that arrives while `valid_o` is still set replaces `data_o` with the new byte, and `valid_o` stays 1.
- R5: A one-cycle high pulse on `rd_i` clears `valid_o` on the next clock edge and leaves `data_o` unchanged.
- R6: A good frame updates the outputs on clock edge number 2 + CPB/2 + 9*CPB. Edges are counted from 0, where edge 0 is the first edge at which `rxd_i` is low. If `rd_i` is high in the cycle before that edge, the new byte wins and `valid_o` stays 1.
- R7: A low pulse on `rxd_i` that ends before half a bit period has passed is not taken as a start bit. The outputs stay unchanged, and the next proper frame is still received.
- R8: Timing realigns on every start-bit falling edge, so back-to-back frames whose bit period differs from CPB by up to 2% are all received correctly.
- R9: CPB is CLK_HZ divided by BAUD, rounded to the nearest integer. At 48 MHz this gives 52 at 921600 baud and 104 at 460800 baud, and an instance built with each setting receives correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd_i | input | 1 | Asynchronous serial line, idles high |
| rd_i | input | 1 | Read strobe; clears the valid flag |
| data_o | output | 8 | Latest good received byte |
| valid_o | output | 1 | Unread good byte is held |

## Verification
The byte values are chosen so that a reversed bit order or a missed edge bit gives a different result: 0x01, 0x80, 0xA5 and 0x3C. Bad-stop frames are sent once while the flag is clear and once while it is set, which separates "ignored" from "cleared" and from "overwritten". Streams sent back to back at bit periods of 51 and 53 cycles pass only if the timing realigns on each start bit. The short glitch and the read strobe landing on the exact commit edge each test one decision in the state machine.

// File: rtl/rx_pkg.sv
package rx_pkg;
   typedef enum logic [1:0] {
      RX_IDLE        = 2'd0,
      RX_START_CHECK = 2'd1,
      RX_DATA        = 2'd2,
      RX_STOP        = 2'd3
   } rx_state_e;

   // Nearest-integer clock cycles per serial bit.
   function automatic int unsigned calc_cpb(input longint unsigned clk_hz,
                                            input longint unsigned baud);
      longint unsigned q;
      q = (clk_hz + (baud / 2)) / baud;
      return 32'(q);
   endfunction
endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rxd_i,
   output logic line_o,
   output logic fall_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("rx_line_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;
   logic              prev;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b1;
               else        chain[0] <= rxd_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= 1'b1;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b1;
      else        prev <= chain[STAGES-1];
   end

   assign line_o = chain[STAGES-1];
   assign fall_o = prev & ~chain[STAGES-1];
endmodule

// File: rtl/rx_bit_timer.sv
module rx_bit_timer #(
   parameter int unsigned CPB = 52
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_half,
   input  logic load_full,
   output logic tick
);
   localparam int unsigned HALF = CPB / 2;
   localparam int unsigned CW   = (CPB > 2) ? $clog2(CPB) : 1;

   generate
      if (CPB < 4) begin : g_bad_cpb
         $error("rx_bit_timer: CPB must be at least 4");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (load_half)      cnt <= CW'(HALF - 1);
      else if (load_full)      cnt <= CW'(CPB - 1);
      else if (cnt != '0)      cnt <= cnt - 1'b1;
   end

   assign tick = (cnt == '0);
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
   import rx_pkg::*;
#(
   parameter int unsigned DATA_BITS = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 line,
   input  logic                 fall,
   input  logic                 tick,
   output logic                 load_half,
   output logic                 load_full,
   output logic                 commit,
   output logic [DATA_BITS-1:0] frame_byte
);
   localparam int unsigned IW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;

   generate
      if (DATA_BITS < 5 || DATA_BITS > 9) begin : g_bad_width
         $error("rx_frame_fsm: DATA_BITS must be 5 to 9");
      end
   endgenerate

   rx_state_e            state, state_nx;
   logic [IW-1:0]        idx;
   logic [DATA_BITS-1:0] shreg;
   logic                 last_bit;

   assign last_bit = (idx == IW'(DATA_BITS - 1));

   always_comb begin
      state_nx  = state;
      load_half = 1'b0;
      load_full = 1'b0;
      commit    = 1'b0;
      unique case (state)
         RX_IDLE: begin
            if (fall) begin
               state_nx  = RX_START_CHECK;
               load_half = 1'b1;
            end
         end
         RX_START_CHECK: begin
            if (tick) begin
               if (line) begin
                  state_nx = RX_IDLE;
               end else begin
                  state_nx  = RX_DATA;
                  load_full = 1'b1;
               end
            end
         end
         RX_DATA: begin
            if (tick) begin
               load_full = 1'b1;
               if (last_bit) state_nx = RX_STOP;
            end
         end
         RX_STOP: begin
            if (tick) begin
               state_nx = RX_IDLE;
               commit   = line;
            end
         end
         default: state_nx = RX_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= RX_IDLE;
         idx   <= '0;
         shreg <= '0;
      end else begin
         state <= state_nx;
         if (state == RX_START_CHECK) begin
            idx <= '0;
         end else if (state == RX_DATA && tick) begin
            shreg <= {line, shreg[DATA_BITS-1:1]};
            idx   <= last_bit ? '0 : idx + 1'b1;
         end
      end
   end

   assign frame_byte = shreg;
endmodule

// File: rtl/rx_hold_reg.sv
module rx_hold_reg #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         commit,
   input  logic [W-1:0] new_byte,
   input  logic         rd,
   output logic [W-1:0] data,
   output logic         valid
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data  <= '0;
         valid <= 1'b0;
      end else if (commit) begin
         data  <= new_byte;
         valid <= 1'b1;
      end else if (rd) begin
         valid <= 1'b0;
      end
   end
endmodule

// File: rtl/serial_byte_rx.sv
module serial_byte_rx #(
   parameter int unsigned CLK_HZ      = 48_000_000,
   parameter int unsigned BAUD        = 921_600,
   parameter int unsigned DATA_BITS   = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rxd_i,
   input  logic                 rd_i,
   output logic [DATA_BITS-1:0] data_o,
   output logic                 valid_o
);
   localparam int unsigned CPB = rx_pkg::calc_cpb(CLK_HZ, BAUD);

   generate
      if (BAUD == 0 || CLK_HZ < 4 * BAUD) begin : g_bad_rate
         $error("serial_byte_rx: CLK_HZ must be at least 4x BAUD");
      end
   endgenerate

   logic                 line_sync;
   logic                 line_fall;
   logic                 tick;
   logic                 load_half;
   logic                 load_full;
   logic                 commit;
   logic [DATA_BITS-1:0] frame_byte;

   rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .rxd_i  (rxd_i),
      .line_o (line_sync),
      .fall_o (line_fall)
   );

   rx_bit_timer #(.CPB(CPB)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_half (load_half),
      .load_full (load_full),
      .tick      (tick)
   );

   rx_frame_fsm #(.DATA_BITS(DATA_BITS)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .line       (line_sync),
      .fall       (line_fall),
      .tick       (tick),
      .load_half  (load_half),
      .load_full  (load_full),
      .commit     (commit),
      .frame_byte (frame_byte)
   );

   rx_hold_reg #(.W(DATA_BITS)) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .commit   (commit),
      .new_byte (frame_byte),
      .rd       (rd_i),
      .data     (data_o),
      .valid    (valid_o)
   );
endmodule

// File: rtl/serial_byte_rx_chk.sv
module serial_byte_rx_chk #(
   parameter int unsigned W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         rd_i,
   input logic         valid_o,
   input logic [W-1:0] data_o,
   input logic         commit,
   input logic [W-1:0] new_byte,
   input logic         line
);
   AST_VALID_RISES_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid_o) |-> $past(commit)) else $error("valid rose without commit"); // R2

   AST_COMMIT_LOADS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> valid_o && data_o == $past(new_byte)) else $error("commit lost"); // R4

   AST_COMMIT_NEEDS_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> line) else $error("commit with low stop bit"); // R3

   AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(data_o)) else $error("data changed without commit"); // R3

   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      rd_i && !commit |=> !valid_o) else $error("read did not clear valid"); // R5

   AST_READ_LOSES_TO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      rd_i && commit |=> valid_o) else $error("read beat commit"); // R6
endmodule

bind serial_byte_rx serial_byte_rx_chk #(.W(DATA_BITS)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rd_i     (rd_i),
   .valid_o  (valid_o),
   .data_o   (data_o),
   .commit   (commit),
   .new_byte (frame_byte),
   .line     (line_sync)
);

// File: tb/serial_byte_rx_bench.sv
`timescale 1ns/1ps
module serial_byte_rx_bench;
   localparam int CPB_F = 52;   // 48 MHz / 921600, rounded
   localparam int CPB_S = 104;  // 48 MHz / 460800, rounded

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rxd_f = 1'b1, rd_f = 1'b0;
   logic       rxd_s = 1'b1, rd_s = 1'b0;
   logic [7:0] data_f, data_s;
   logic       valid_f, valid_s;
   int         total = 0;
   int         bad = 0;

   always #2 clk = ~clk;

   serial_byte_rx #(.CLK_HZ(48_000_000), .BAUD(921_600)) u_serial_byte_rx (
      .clk(clk), .rst_n(rst_n), .rxd_i(rxd_f), .rd_i(rd_f),
      .data_o(data_f), .valid_o(valid_f));

   serial_byte_rx #(.CLK_HZ(48_000_000), .BAUD(460_800)) u_serial_byte_rx_slow (
      .clk(clk), .rst_n(rst_n), .rxd_i(rxd_s), .rd_i(rd_s),
      .data_o(data_s), .valid_o(valid_s));

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // Line level for position e in a frame of bit length bc.
   function automatic logic frame_bit(input logic [7:0] b, input int e,
                                      input int bc, input logic stop_v);
      int k;
      k = e / bc;
      if (k == 0) return 1'b0;
      if (k <= 8) return b[k-1];
      return stop_v;
   endfunction

   // Called at a negedge; rd_at < 0 means no read strobe.
   task automatic frame_fast(input logic [7:0] b, input int bc, input logic stop_v,
                             input int rd_at, input int gap);
      for (int e = 0; e < 10 * bc; e++) begin
         rxd_f = frame_bit(b, e, bc, stop_v);
         rd_f  = (e == rd_at);
         @(posedge clk); @(negedge clk);
      end
      rd_f  = 1'b0;
      rxd_f = 1'b1;
      for (int g = 0; g < gap; g++) begin
         @(posedge clk); @(negedge clk);
      end
   endtask

   task automatic frame_slow(input logic [7:0] b);
      for (int e = 0; e < 10 * CPB_S; e++) begin
         rxd_s = frame_bit(b, e, CPB_S, 1'b1);
         @(posedge clk); @(negedge clk);
      end
      rxd_s = 1'b1;
      repeat (2 * CPB_S) begin @(posedge clk); @(negedge clk); end
   endtask

   task automatic read_fast();
      rd_f = 1'b1;
      @(posedge clk); @(negedge clk);
      rd_f = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 valid after reset", valid_f, 0);
      chk("R1 data after reset", data_f, 8'h00);
   endtask

   task automatic t_basic();
      frame_fast(8'hA5, CPB_F, 1'b1, -1, 2 * CPB_F);
      chk("R2 valid after 0xA5", valid_f, 1);
      chk("R2 data 0xA5", data_f, 8'hA5);
      frame_fast(8'h01, CPB_F, 1'b1, -1, 2 * CPB_F);
      chk("R2 lsb-first 0x01", data_f, 8'h01);
   endtask

   task automatic t_read();
      read_fast();
      chk("R5 valid cleared by read", valid_f, 0);
      chk("R5 data kept after read", data_f, 8'h01);
   endtask

   task automatic t_bad_stop();
      frame_fast(8'h7E, CPB_F, 1'b0, -1, 2 * CPB_F);
      chk("R3 bad stop, valid stays 0", valid_f, 0);
      chk("R3 bad stop, data kept", data_f, 8'h01);
      frame_fast(8'h55, CPB_F, 1'b1, -1, 2 * CPB_F);
      frame_fast(8'hAA, CPB_F, 1'b0, -1, 2 * CPB_F);
      chk("R3 bad stop, valid stays 1", valid_f, 1);
      chk("R3 bad stop, data 0x55 kept", data_f, 8'h55);
   endtask

   task automatic t_overwrite();
      frame_fast(8'h80, CPB_F, 1'b1, -1, 2 * CPB_F);
      frame_fast(8'h3C, CPB_F, 1'b1, -1, 2 * CPB_F);
      chk("R4 unread byte replaced", data_f, 8'h3C);
      chk("R4 valid still set", valid_f, 1);
   endtask

   task automatic t_same_cycle();
      int edge_n;
      edge_n = 2 + CPB_F / 2 + 9 * CPB_F;
      frame_fast(8'hC6, CPB_F, 1'b1, edge_n, 2 * CPB_F);
      chk("R6 new byte wins over read", data_f, 8'hC6);
      chk("R6 valid stays set", valid_f, 1);
      // one cycle earlier: read lands first, commit then sets again
      read_fast();
      frame_fast(8'h39, CPB_F, 1'b1, edge_n - 1, 0);
      chk("R6 commit after read sets valid", valid_f, 1);
      chk("R6 commit edge data", data_f, 8'h39);
      repeat (2 * CPB_F) begin @(posedge clk); @(negedge clk); end
   endtask

   task automatic t_glitch();
      read_fast();
      rxd_f = 1'b0;
      repeat (10) begin @(posedge clk); @(negedge clk); end
      rxd_f = 1'b1;
      repeat (12 * CPB_F) begin @(posedge clk); @(negedge clk); end
      chk("R7 glitch, valid stays 0", valid_f, 0);
      chk("R7 glitch, data kept", data_f, 8'h39);
      frame_fast(8'h5A, CPB_F, 1'b1, -1, 2 * CPB_F);
      chk("R7 frame after glitch", data_f, 8'h5A);
   endtask

   task automatic t_drift(input int bc);
      logic [7:0] seq [3];
      seq[0] = 8'h12; seq[1] = 8'hED; seq[2] = 8'h81;
      for (int i = 0; i < 3; i++) begin
         frame_fast(seq[i], bc, 1'b1, -1, 0);
         chk($sformatf("R8 back-to-back bc=%0d byte %0d", bc, i), data_f, seq[i]);
      end
      repeat (2 * CPB_F) begin @(posedge clk); @(negedge clk); end
   endtask

   task automatic t_slow();
      chk("R9 slow instance reset", valid_s, 0);
      frame_slow(8'hC3);
      chk("R9 460800 instance data", data_s, 8'hC3);
      chk("R9 460800 instance valid", valid_s, 1);
      chk("R9 fast instance untouched", data_f, 8'h81);
   endtask

   initial begin
      #(200_000 * 4);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      t_reset();
      t_basic();
      t_read();
      t_bad_stop();
      t_overwrite();
      t_same_cycle();
      t_glitch();
      t_drift(53);
      t_drift(51);
      t_slow();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule